// File: doc/BRIEF.md
# Parallel-In Serial-Out Shift Register

This block is an eight-stage shift register. A word enters it in parallel and leaves it one bit at a time. A fast system clock samples every external input, so the external shift clocks are treated as plain data. The block finds rising edges on those clocks inside the system clock domain. Two external clock pins act the same way and are merged by an OR. A high level on either pin therefore blocks edges on the other pin, so either pin can serve as a clock inhibit.

A mode input selects between loading and shifting. While the mode input is low, the parallel word is copied into every stage on each system cycle, and this load overrides any clock activity. While the mode input is high, each detected rise of the merged clock moves the register one place. The serial input enters at stage 0, and stage 7 drives the true and complemented serial outputs.

Top module: `piso_shifter`

## Requirements
- R1: A synchronous active-high reset clears all stages and the clock-edge history. After reset, q_out is 0 and q_out_n is 1.
- R2: While mode_shift is 0, every stage takes the value of par_in, whatever clk_a and clk_b are doing.
- R3: While mode_shift stays 0, later changes on par_in keep entering the stages. After mode_shift rises, the register holds the last word that was present.
- R4: A clock edge seen while mode_shift is 0 causes no shift. The load wins.
- R5: With mode_shift at 1, a rise of (clk_a OR clk_b) shifts the register exactly once. clk_a and clk_b are interchangeable.
- R6: While one clock input is held at 1, a rise or toggle of the other clock input causes no shift.
- R7: If one clock input rises while the other is at 0, that rise causes one shift.
- R8: On each shift, ser_in enters stage 0 and every stage moves one place toward stage 7. q_out shows stage 7, and q_out_n is its complement.
- R9: Every input is registered before use. A change on an input shows up at the outputs after the second rising edge of clk, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it must run faster than the external clocks |
| rst | input | 1 | Synchronous active-high reset |
| par_in | input | 8 | Parallel word; bit 7 is the first bit shifted out |
| mode_shift | input | 1 | 0 = transparent parallel load, 1 = shift on clock edges |
| clk_a | input | 1 | External shift clock; either clock input can act as the inhibit |
| clk_b | input | 1 | External shift clock; either clock input can act as the inhibit |
| ser_in | input | 1 | Serial data shifted into stage 0 |
| q_out | output | 1 | Stage 7 |
| q_out_n | output | 1 | Complement of stage 7 |

## Verification
The bench raises one clock pin while the other pin is high. A design that gated on one pin only, or that detected edges per pin, would shift there when it should not. The bench also raises the inhibit pin while the other pin is low. A design built with an AND instead of the OR/NOR merge would miss that shift. Clock edges are applied while the mode input is low, which catches a design that lets the shift win over the load. The bench checks the two-cycle latency and the transparent load, which exposes a missing input register or a load captured only on the edge of the mode input. A seeded random walk over all inputs then compares both outputs against a reference model after every step.

// File: rtl/piso_pkg.sv
package piso_pkg;

    localparam int PISO_W = 8;

    typedef struct packed {
        logic mode;
        logic clk_or;
        logic ser;
    } ctrl_t;

    function automatic logic [PISO_W-1:0] shift_one(
        input logic [PISO_W-1:0] cur,
        input logic              bit_in
    );
        return {cur[PISO_W-2:0], bit_in};
    endfunction

endpackage

// File: rtl/piso_in_sync.sv
module piso_in_sync
    import piso_pkg::*;
#(
    parameter int W     = PISO_W,
    parameter int N_CLK = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     par_raw,
    input  logic             mode_raw,
    input  logic [N_CLK-1:0] clks_raw,
    input  logic             ser_raw,
    output logic [W-1:0]     par_q,
    output ctrl_t            ctrl_q
);
    logic [N_CLK-1:0] clk_reg;
    logic [N_CLK:0]   or_chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            par_q       <= '0;
            ctrl_q.mode <= 1'b0;
            ctrl_q.ser  <= 1'b0;
            clk_reg     <= '0;
        end else begin
            par_q       <= par_raw;
            ctrl_q.mode <= mode_raw;
            ctrl_q.ser  <= ser_raw;
            clk_reg     <= clks_raw;
        end
    end

    assign or_chain[0] = 1'b0;
    for (genvar i = 0; i < N_CLK; i++) begin : g_or
        assign or_chain[i+1] = or_chain[i] | clk_reg[i];
    end
    assign ctrl_q.clk_or = or_chain[N_CLK];

endmodule

// File: rtl/piso_edge_det.sv
module piso_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic lvl_prev;

    always_ff @(posedge clk) begin
        if (rst) lvl_prev <= 1'b0;
        else     lvl_prev <= lvl;
    end

    assign rise = lvl & ~lvl_prev;

    a_r5_single_rise: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/piso_stages.sv
module piso_stages
    import piso_pkg::*;
#(
    parameter int W = PISO_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] par,
    input  logic         mode,
    input  logic         ser,
    input  logic         step,
    output logic [W-1:0] stages
);
    always_ff @(posedge clk) begin
        if (rst)       stages <= '0;
        else if (!mode) stages <= par;
        else if (step)  stages <= {stages[W-2:0], ser};
    end

    a_r2_load_copies: assert property (@(posedge clk) disable iff (rst)
        !mode |=> stages == $past(par));
    a_r4_hold_without_edge: assert property (@(posedge clk) disable iff (rst)
        (mode && !step) |=> $stable(stages));
    a_r8_shift_order: assert property (@(posedge clk) disable iff (rst)
        (mode && step) |=> stages == shift_one($past(stages), $past(ser)));
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> stages == '0);

endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
    import piso_pkg::*;
#(
    parameter int WIDTH = PISO_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] par_in,
    input  logic             mode_shift,
    input  logic             clk_a,
    input  logic             clk_b,
    input  logic             ser_in,
    output logic             q_out,
    output logic             q_out_n
);
    localparam int LAST = WIDTH - 1;

    logic [WIDTH-1:0] par_s;
    ctrl_t            ctrl_s;
    logic             step;
    logic [WIDTH-1:0] stages;

    piso_in_sync #(.W(WIDTH), .N_CLK(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .par_raw  (par_in),
        .mode_raw (mode_shift),
        .clks_raw ({clk_b, clk_a}),
        .ser_raw  (ser_in),
        .par_q    (par_s),
        .ctrl_q   (ctrl_s)
    );

    piso_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (ctrl_s.clk_or),
        .rise (step)
    );

    piso_stages #(.W(WIDTH)) u_stages (
        .clk    (clk),
        .rst    (rst),
        .par    (par_s),
        .mode   (ctrl_s.mode),
        .ser    (ctrl_s.ser),
        .step   (step),
        .stages (stages)
    );

    assign q_out   = stages[LAST];
    assign q_out_n = ~stages[LAST];

    a_r9_load_latency: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_s.mode && !$past(rst)) |=> q_out == $past(par_in[LAST], 2));
    a_r6_no_step_while_held: assert property (@(posedge clk) disable iff (rst)
        ($past(ctrl_s.clk_or) && ctrl_s.clk_or) |-> !step);

endmodule

// File: tb/piso_shifter_bench.sv
module piso_shifter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] par_in = '0;
    logic         mode_shift = 1'b1;
    logic         clk_a = 1'b0;
    logic         clk_b = 1'b0;
    logic         ser_in = 1'b0;
    logic         q_out, q_out_n;

    int n_checks = 0;
    int n_fail   = 0;
    logic [W-1:0] model = '0;
    logic         prev_or = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    piso_shifter u_piso_shifter (
        .clk(clk), .rst(rst), .par_in(par_in), .mode_shift(mode_shift),
        .clk_a(clk_a), .clk_b(clk_b), .ser_in(ser_in),
        .q_out(q_out), .q_out_n(q_out_n)
    );

    function automatic logic [W-1:0] next_model(
        input logic [W-1:0] cur, input logic a, input logic b,
        input logic m, input logic [W-1:0] p, input logic s, input logic pv);
        if (!m)                return p;
        else if ((a | b) && !pv) return {cur[W-2:0], s};
        else                   return cur;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_out(input string req);
        check(req, q_out, model[W-1]);
        check(req, q_out_n, ~model[W-1]);
    endtask

    task automatic do_op(input string req, input logic a, input logic b,
                         input logic m, input logic [W-1:0] p, input logic s);
        @(negedge clk);
        clk_a = a; clk_b = b; mode_shift = m; par_in = p; ser_in = s;
        repeat (3) @(negedge clk);
        model   = next_model(model, a, b, m, p, s, prev_or);
        prev_or = a | b;
        check_out(req);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++; n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", q_out, 1'b0);
        check("R1", q_out_n, 1'b1);

        // R2: load with clocks wiggling
        do_op("R2", 1'b1, 1'b0, 1'b0, 8'hA5, 1'b0);
        do_op("R2", 1'b0, 1'b1, 1'b0, 8'h5A, 1'b1);
        // R3: transparent load, last value held
        do_op("R3", 1'b0, 1'b0, 1'b0, 8'h81, 1'b0);
        do_op("R3", 1'b0, 1'b0, 1'b0, 8'h7E, 1'b0);
        do_op("R3", 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0);
        // R4: edge while loading -> load wins
        do_op("R4", 1'b1, 1'b0, 1'b0, 8'h80, 1'b1);
        do_op("R4", 1'b0, 1'b0, 1'b1, 8'h00, 1'b1);
        // R5/R8: shift via clk_a, then clk_b
        do_op("R8", 1'b0, 1'b0, 1'b0, 8'hC0, 1'b0);
        do_op("R8", 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
        do_op("R5", 1'b1, 1'b0, 1'b1, 8'h00, 1'b0);
        do_op("R5", 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
        do_op("R5", 1'b0, 1'b1, 1'b1, 8'h00, 1'b1);
        // R6: other clock high, inhibit rises/toggles -> no shift
        do_op("R6", 1'b1, 1'b1, 1'b1, 8'h00, 1'b0);
        do_op("R6", 1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
        do_op("R6", 1'b1, 1'b1, 1'b1, 8'h00, 1'b0);
        do_op("R6", 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
        // R7: inhibit rises with other low -> one shift
        do_op("R7", 1'b0, 1'b1, 1'b1, 8'h00, 1'b1);
        do_op("R7", 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);

        // R9: two-cycle latency of a load
        @(negedge clk);
        mode_shift = 1'b0; par_in = {~model[W-1], 7'h00};
        @(negedge clk);
        check("R9", q_out, model[W-1]);
        @(negedge clk);
        model = par_in;
        check("R9", q_out, model[W-1]);
        prev_or = clk_a | clk_b;

        // R8: drain eight serial bits, ser_in pattern enters stage 0
        do_op("R8", 1'b0, 1'b0, 1'b0, 8'h96, 1'b0);
        for (int i = 0; i < 16; i++)
            do_op("R8", i[0], 1'b0, 1'b1, 8'h00, i[1]);

        // random walk, all requirements (R2..R8)
        for (int i = 0; i < 400; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            do_op("R5", r[0], r[1], (r[3:2] != 2'b00), 8'($urandom), r[2]);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule